// File: doc/BRIEF.md
# Dual-Mode Packet Framing Checker

This block sits after lane merging in a serial camera receiver. It takes one aligned byte stream, a byte with a valid strobe plus single-cycle start-of-transmission and end-of-transmission markers, and finds the packet boundaries in it. It can do this in one of two ways, chosen by a static mode input. In header mode every transmission opens with a four-byte header. The block corrects that header with its embedded code, decodes the packet type and word count, counts the payload, and checks the trailing CRC. In sync-code mode, packets are marked by four-byte start and end sequences inside the stream. An optional programmed length lets the block give up on a packet whose end sequence never came, as soon as the length runs out. Because of this, a lost end code costs one packet and not two.

Each accepted packet gives a `pkt_start` pulse and a `pkt_done` pulse, together with its channel, type, word count and short/long class. Errors and the per-packet event go into sticky flags. Each flag is cleared by writing one to its `flag_clr` bit. The single `irq` line is the OR of the flags whose enable bits are set. The state machine has these states:
- ST_IDLE: waits for `rx_sot` in header mode, or for a start sequence in sync mode.
- ST_HDR: collects the four header bytes.
- ST_PAY: counts payload bytes.
- ST_CRC: takes the two CRC bytes.
- ST_DRAIN: waits for `rx_eot` after a finished or rejected packet.
- ST_BODY: is inside a sync-framed packet.

Its transitions are:
- IDLE to HDR on start-of-transmission.
- HDR to PAY, CRC or DRAIN after the fourth header byte.
- PAY to CRC on the last payload byte.
- CRC to DRAIN on the second CRC byte.
- Any header state to IDLE on end-of-transmission, or back to HDR on a new start-of-transmission.
- IDLE to BODY on a start sequence.
- BODY to IDLE on an end sequence or when the length runs out.
- BODY to BODY on a repeated start sequence.
- Any state to IDLE on a stall timeout.

Top module: `pkt_frame_chk`

## Requirements
- R1: The fourth header byte carries a check code in bits [5:0]; bits [7:6] are ignored. Header data bit k (k = 8*byte + bit, over the first three bytes) has column code c(k), the k-th 6-bit value in ascending order with an odd population count of at least 3. The check code is the XOR of c(k) over all set data bits. A syndrome of weight one, or one that equals some c(k), is corrected (data bit k is flipped if so) and sets flag bit 0. This applies in header mode only.
- R2: A nonzero syndrome of even weight, or an odd one that matches no column, sets flag bit 1. No packet is reported, and the bytes up to `rx_eot` are ignored.
- R3: In the header, byte 0 gives the channel in [7:6] and the type in [5:0], and bytes 1 and 2 give the word count, low byte first. Types 0x00 to 0x0F are short packets. For a short packet, `pkt_start` and `pkt_done` pulse together in the cycle after the fourth byte is accepted, with `pkt_long`=0.
- R4: A long packet carries word-count payload bytes and then a 16-bit CRC, low byte first. The CRC is computed bit by bit, least significant bit first, with reflected polynomial 0x8408 (x^16+x^12+x^5+1), seed 0xFFFF, and no final inversion. `pkt_done` pulses in the cycle after the second CRC byte. A mismatch sets flag bit 2 in that same cycle.
- R5: In header mode, `rx_eot` before the last CRC byte sets flag bit 6. `rx_sot` while a transmission is still open sets flag bit 3.
- R6: In sync-code mode, the sequence FF 00 00 followed by a code byte is a marker. Codes 0x80 and 0x82 open a packet, and 0x81 and 0x83 close one. `pkt_start` pulses after an opening code byte. `pkt_done` pulses after a closing code byte, with `pkt_wc` equal to the number of bytes between the two sequences.
- R7: In sync-code mode, a closing sequence while no packet is open, or an opening sequence while one is open, sets flag bit 3. The second case restarts the packet.
- R8: When `len_en` is set and `len_bytes`+4 bytes have followed the opening code without a closing sequence, flag bit 4 is set on that byte. The packet is abandoned, and the next opening sequence is accepted without setting flag bit 3.
- R9: With `tmo_limit` nonzero, `tmo_limit` consecutive cycles without a valid byte while not idle set flag bit 5 and return the block to idle.
- R10: Every `pkt_done` pulse sets flag bit 7.
- R11: Flags are sticky until their `flag_clr` bit is pulsed. `irq` equals the OR of `flags & irq_en` in the same cycle.
- R12: After reset, all flags, `irq`, `pkt_start` and `pkt_done` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_sync | input | 1 | 0 selects header framing, 1 selects sync-code framing |
| len_en | input | 1 | Enables the programmed length in sync-code mode |
| len_bytes | input | LEN_W | Expected payload length in sync-code mode |
| tmo_limit | input | TMO_W | Stall limit in cycles; 0 disables it |
| irq_en | input | 8 | Per-flag interrupt enables |
| flag_clr | input | 8 | Write-one-to-clear pulses for the flags |
| rx_valid | input | 1 | Byte valid |
| rx_byte | input | 8 | Received byte |
| rx_sot | input | 1 | Start-of-transmission marker |
| rx_eot | input | 1 | End-of-transmission marker |
| pkt_start | output | 1 | Packet accepted pulse |
| pkt_done | output | 1 | Packet finished pulse |
| pkt_long | output | 1 | Current packet is long |
| pkt_vc | output | 2 | Channel of the current packet |
| pkt_dtype | output | 6 | Type of the current packet, or the opening code in sync mode |
| pkt_wc | output | 16 | Word count, or the measured length in sync mode |
| flags | output | 8 | Sticky flags |
| irq | output | 1 | Interrupt |

## Verification
A wrong syndrome table or correction step shows up one cycle after the fourth header byte. It appears as a wrong `pkt_wc` or type, or as a correction or uncorrectable flag on a clean header. A payload counter that is off by one moves the `pkt_done` pulse, leaves the CRC comparison misaligned, and raises flag bit 2 one cycle after the second CRC byte. In sync-code mode, an off-by-one length counter either flags bit 4 on a well-formed packet or stays silent past the programmed length. Stale packet state after an abandon shows up as flag bit 3 when the next opening sequence arrives.

// File: rtl/pkt_frame_pkg.sv
package pkt_frame_pkg;

    localparam int HDR_BITS = 24;
    localparam int PAR_W    = 6;
    localparam int WC_W     = 16;
    localparam int NFLAG    = 8;

    localparam int F_HDR_FIX = 0;
    localparam int F_HDR_BAD = 1;
    localparam int F_CRC_BAD = 2;
    localparam int F_ORDER   = 3;
    localparam int F_NO_END  = 4;
    localparam int F_STALL   = 5;
    localparam int F_EARLY   = 6;
    localparam int F_EVT     = 7;

    localparam logic [7:0] SC_LINE_OPEN  = 8'h80;
    localparam logic [7:0] SC_LINE_CLOSE = 8'h81;
    localparam logic [7:0] SC_FRM_OPEN   = 8'h82;
    localparam logic [7:0] SC_FRM_CLOSE  = 8'h83;

    localparam logic [15:0] CRC_SEED = 16'hFFFF;
    localparam logic [15:0] CRC_POLY = 16'h8408;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HDR,
        ST_PAY,
        ST_CRC,
        ST_DRAIN,
        ST_BODY
    } frm_state_t;

    function automatic logic [PAR_W-1:0] ecc_col(input int idx);
        logic [PAR_W-1:0] r;
        logic [PAR_W-1:0] v6;
        int n;
        r = '0;
        n = 0;
        for (int v = 0; v < (1 << PAR_W); v++) begin
            v6 = PAR_W'(v);
            if (($countones(v6) >= 3) && (^v6)) begin
                if (n == idx) r = v6;
                n++;
            end
        end
        return r;
    endfunction

    function automatic logic [15:0] crc_step(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] r;
        r = c;
        for (int i = 0; i < 8; i++) begin
            if (r[0] ^ d[i]) r = (r >> 1) ^ CRC_POLY;
            else             r = r >> 1;
        end
        return r;
    endfunction

endpackage

// File: rtl/pkt_crc16.sv
module pkt_crc16
    import pkt_frame_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        init,
    input  logic        en,
    input  logic [7:0]  din,
    output logic [15:0] crc_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    crc_q <= CRC_SEED;
        else if (init) crc_q <= CRC_SEED;
        else if (en)   crc_q <= crc_step(crc_q, din);
    end

endmodule

// File: rtl/pkt_hdr_ecc.sv
module pkt_hdr_ecc
    import pkt_frame_pkg::*;
(
    input  logic [HDR_BITS-1:0] hdr_in,
    input  logic [PAR_W-1:0]    par_in,
    output logic [HDR_BITS-1:0] hdr_out,
    output logic                fixed,
    output logic                bad
);

    logic [PAR_W-1:0] col [HDR_BITS];

    for (genvar g = 0; g < HDR_BITS; g++) begin : g_col
        localparam logic [PAR_W-1:0] CODE = ecc_col(g);
        assign col[g] = CODE;
    end

    logic [PAR_W-1:0] calc;
    logic [PAR_W-1:0] syn;
    logic             hit;

    always_comb begin
        calc = '0;
        for (int i = 0; i < HDR_BITS; i++) begin
            if (hdr_in[i]) calc = calc ^ col[i];
        end
        syn     = calc ^ par_in;
        hdr_out = hdr_in;
        fixed   = 1'b0;
        bad     = 1'b0;
        hit     = 1'b0;
        if (syn != '0) begin
            if (!(^syn)) begin
                bad = 1'b1;
            end else if ($countones(syn) == 1) begin
                fixed = 1'b1;
            end else begin
                for (int i = 0; i < HDR_BITS; i++) begin
                    if (syn == col[i]) begin
                        hdr_out[i] = ~hdr_in[i];
                        hit        = 1'b1;
                    end
                end
                fixed = hit;
                bad   = !hit;
            end
        end
    end

endmodule

// File: rtl/pkt_sync_match.sv
module pkt_sync_match
    import pkt_frame_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       shift_en,
    input  logic [7:0] byte_in,
    output logic       hit_open,
    output logic       hit_close
);

    logic [7:0] h2, h1, h0;
    logic       lead;

    assign lead      = (h2 == 8'hFF) && (h1 == 8'h00) && (h0 == 8'h00);
    assign hit_open  = lead && ((byte_in == SC_LINE_OPEN)  || (byte_in == SC_FRM_OPEN));
    assign hit_close = lead && ((byte_in == SC_LINE_CLOSE) || (byte_in == SC_FRM_CLOSE));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            h2 <= '0;
            h1 <= '0;
            h0 <= '0;
        end else if (shift_en) begin
            h2 <= h1;
            h1 <= h0;
            h0 <= byte_in;
        end
    end

endmodule

// File: rtl/pkt_flag_bank.sv
module pkt_flag_bank #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    input  logic [N-1:0] en,
    output logic [N-1:0] flags_q,
    output logic         irq
);

    for (genvar i = 0; i < N; i++) begin : g_bit
        logic b;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      b <= 1'b0;
            else if (set[i]) b <= 1'b1;
            else if (clr[i]) b <= 1'b0;
        end
        assign flags_q[i] = b;
    end

    assign irq = |(flags_q & en);

endmodule

// File: rtl/pkt_frame_chk.sv
module pkt_frame_chk
    import pkt_frame_pkg::*;
#(
    parameter int LEN_W = 16,
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_sync,
    input  logic             len_en,
    input  logic [LEN_W-1:0] len_bytes,
    input  logic [TMO_W-1:0] tmo_limit,
    input  logic [NFLAG-1:0] irq_en,
    input  logic [NFLAG-1:0] flag_clr,
    input  logic             rx_valid,
    input  logic [7:0]       rx_byte,
    input  logic             rx_sot,
    input  logic             rx_eot,
    output logic             pkt_start,
    output logic             pkt_done,
    output logic             pkt_long,
    output logic [1:0]       pkt_vc,
    output logic [5:0]       pkt_dtype,
    output logic [WC_W-1:0]  pkt_wc,
    output logic [NFLAG-1:0] flags,
    output logic             irq
);

    localparam int CNT_W = LEN_W + 1;
    localparam logic [CNT_W-1:0] SEQ_LEN = CNT_W'(4);
    localparam logic [CNT_W-1:0] SEQ_LEAD = CNT_W'(3);

    frm_state_t st_q, st_d;

    logic [7:0]       hb0, hb1, hb2;
    logic [1:0]       hcnt;
    logic [WC_W-1:0]  pay_cnt, wc_q;
    logic [7:0]       crc_lo;
    logic [TMO_W-1:0] stall_cnt;
    logic [CNT_W-1:0] scnt;

    logic [HDR_BITS-1:0] hdr_fix;
    logic                ecc_fixed, ecc_bad;
    logic [15:0]         crc_q;
    logic                sm_open, sm_close;
    logic [NFLAG-1:0]    fl_set;

    pkt_hdr_ecc u_ecc (
        .hdr_in (({hb2, hb1, hb0})),
        .par_in (rx_byte[PAR_W-1:0]),
        .hdr_out(hdr_fix),
        .fixed  (ecc_fixed),
        .bad    (ecc_bad)
    );

    logic [5:0]      dec_dt;
    logic [1:0]      dec_vc;
    logic [WC_W-1:0] dec_wc;
    logic            dec_short;

    assign dec_dt    = hdr_fix[5:0];
    assign dec_vc    = hdr_fix[7:6];
    assign dec_wc    = hdr_fix[23:8];
    assign dec_short = (dec_dt[5:4] == 2'b00);

    logic hdr_busy, hdr_open;
    logic hdr_last, hdr_ok, pay_last, crc_last;
    logic sv_open, sv_close, len_hit, stall_hit;
    logic start_d, done_d;

    assign hdr_busy  = (st_q == ST_HDR) || (st_q == ST_PAY) || (st_q == ST_CRC);
    assign hdr_open  = hdr_busy || (st_q == ST_DRAIN);
    assign hdr_last  = (st_q == ST_HDR) && rx_valid && (hcnt == 2'd3);
    assign hdr_ok    = hdr_last && !ecc_bad;
    assign pay_last  = (st_q == ST_PAY) && rx_valid && (pay_cnt == wc_q - WC_W'(1));
    assign crc_last  = (st_q == ST_CRC) && rx_valid && hcnt[0];
    assign sv_open   = mode_sync && rx_valid && sm_open &&
                       ((st_q == ST_IDLE) || (st_q == ST_BODY));
    assign sv_close  = (st_q == ST_BODY) && rx_valid && sm_close;
    assign len_hit   = (st_q == ST_BODY) && rx_valid && len_en && !sm_close && !sm_open &&
                       ((scnt + CNT_W'(1)) == ({1'b0, len_bytes} + SEQ_LEN));
    assign stall_hit = (st_q != ST_IDLE) && !rx_valid && (tmo_limit != '0) &&
                       (stall_cnt == tmo_limit - TMO_W'(1));

    assign start_d = hdr_ok || sv_open;
    assign done_d  = (hdr_ok && dec_short) || crc_last || sv_close;

    pkt_crc16 u_crc (
        .clk  (clk),
        .rst_n(rst_n),
        .init (hdr_ok),
        .en   ((st_q == ST_PAY) && rx_valid),
        .din  (rx_byte),
        .crc_q(crc_q)
    );

    pkt_sync_match u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (mode_sync && rx_valid),
        .byte_in  (rx_byte),
        .hit_open (sm_open),
        .hit_close(sm_close)
    );

    always_comb begin
        fl_set            = '0;
        fl_set[F_HDR_FIX] = hdr_last && ecc_fixed;
        fl_set[F_HDR_BAD] = hdr_last && ecc_bad;
        fl_set[F_CRC_BAD] = crc_last && ({rx_byte, crc_lo} != crc_q);
        fl_set[F_ORDER]   = (!mode_sync && rx_sot && hdr_open) ||
                            (mode_sync && rx_valid && sm_close && (st_q == ST_IDLE)) ||
                            ((st_q == ST_BODY) && rx_valid && sm_open);
        fl_set[F_NO_END]  = len_hit;
        fl_set[F_STALL]   = stall_hit;
        fl_set[F_EARLY]   = !mode_sync && rx_eot && !rx_sot && hdr_busy;
        fl_set[F_EVT]     = done_d;
    end

    pkt_flag_bank #(.N(NFLAG)) u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .set    (fl_set),
        .clr    (flag_clr),
        .en     (irq_en),
        .flags_q(flags),
        .irq    (irq)
    );

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (mode_sync) begin
                    if (sv_open) st_d = ST_BODY;
                end else if (rx_sot) begin
                    st_d = ST_HDR;
                end
            end
            ST_HDR: begin
                if (rx_sot)        st_d = ST_HDR;
                else if (rx_eot)   st_d = ST_IDLE;
                else if (hdr_last) begin
                    if (ecc_bad || dec_short) st_d = ST_DRAIN;
                    else if (dec_wc == '0)    st_d = ST_CRC;
                    else                      st_d = ST_PAY;
                end
            end
            ST_PAY: begin
                if (rx_sot)        st_d = ST_HDR;
                else if (rx_eot)   st_d = ST_IDLE;
                else if (pay_last) st_d = ST_CRC;
            end
            ST_CRC: begin
                if (rx_sot)        st_d = ST_HDR;
                else if (rx_eot)   st_d = ST_IDLE;
                else if (crc_last) st_d = ST_DRAIN;
            end
            ST_DRAIN: begin
                if (rx_sot)        st_d = ST_HDR;
                else if (rx_eot)   st_d = ST_IDLE;
            end
            ST_BODY: begin
                if (sv_close || len_hit) st_d = ST_IDLE;
            end
            default: st_d = ST_IDLE;
        endcase
        if (stall_hit) st_d = ST_IDLE;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hb0       <= '0;
            hb1       <= '0;
            hb2       <= '0;
            hcnt      <= '0;
            pay_cnt   <= '0;
            wc_q      <= '0;
            crc_lo    <= '0;
            stall_cnt <= '0;
            scnt      <= '0;
            pkt_start <= 1'b0;
            pkt_done  <= 1'b0;
            pkt_long  <= 1'b0;
            pkt_vc    <= '0;
            pkt_dtype <= '0;
            pkt_wc    <= '0;
        end else begin
            pkt_start <= start_d;
            pkt_done  <= done_d;

            if ((st_q == ST_IDLE) || rx_valid || stall_hit) stall_cnt <= '0;
            else                                            stall_cnt <= stall_cnt + TMO_W'(1);

            if (!mode_sync && rx_sot) begin
                hcnt <= '0;
            end else if ((st_q == ST_HDR) && rx_valid) begin
                unique case (hcnt)
                    2'd0: hb0 <= rx_byte;
                    2'd1: hb1 <= rx_byte;
                    2'd2: hb2 <= rx_byte;
                    default: ;
                endcase
                hcnt <= (hcnt == 2'd3) ? 2'd0 : hcnt + 2'd1;
            end else if ((st_q == ST_CRC) && rx_valid) begin
                crc_lo <= rx_byte;
                hcnt   <= hcnt + 2'd1;
            end

            if (hdr_ok) begin
                pkt_vc    <= dec_vc;
                pkt_dtype <= dec_dt;
                pkt_wc    <= dec_wc;
                pkt_long  <= !dec_short;
                wc_q      <= dec_wc;
                pay_cnt   <= '0;
            end else if ((st_q == ST_PAY) && rx_valid) begin
                pay_cnt <= pay_cnt + WC_W'(1);
            end

            if (sv_open) begin
                scnt      <= '0;
                pkt_vc    <= '0;
                pkt_dtype <= rx_byte[5:0];
                pkt_long  <= 1'b1;
                pkt_wc    <= '0;
            end else if ((st_q == ST_BODY) && rx_valid) begin
                scnt <= scnt + CNT_W'(1);
                if (sv_close) pkt_wc <= WC_W'(scnt - SEQ_LEAD);
            end
        end
    end

endmodule

// File: rtl/pkt_frame_chk_sva.sv
module pkt_frame_chk_sva
    import pkt_frame_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             mode_sync,
    input logic [NFLAG-1:0] flag_clr,
    input logic [NFLAG-1:0] flags,
    input logic             pkt_done
);

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(flags) & ~$past(flag_clr)) & ~flags) == '0)); // R11

    AST_DONE_EVT: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_done |-> flags[F_EVT]); // R10

    AST_NO_END_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[F_NO_END]) |-> mode_sync); // R8

    AST_ECC_HDR_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[F_HDR_BAD]) |-> !mode_sync); // R2

    AST_CRC_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[F_CRC_BAD]) |-> pkt_done); // R4

endmodule

bind pkt_frame_chk pkt_frame_chk_sva u_sva (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_sync(mode_sync),
    .flag_clr (flag_clr),
    .flags    (flags),
    .pkt_done (pkt_done)
);

// File: tb/sim_pkt_frame_chk.sv
`timescale 1ns/1ps
module sim_pkt_frame_chk;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_sync = 1'b0;
    logic        len_en = 1'b0;
    logic [15:0] len_bytes = '0;
    logic [15:0] tmo_limit = '0;
    logic [7:0]  irq_en = '0;
    logic [7:0]  flag_clr = '0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        rx_sot = 1'b0;
    logic        rx_eot = 1'b0;
    logic        pkt_start, pkt_done, pkt_long, irq;
    logic [1:0]  pkt_vc;
    logic [5:0]  pkt_dtype;
    logic [15:0] pkt_wc;
    logic [7:0]  flags;

    int checks = 0;
    int bad = 0;
    int n_start = 0;
    int n_done = 0;
    logic [15:0] last_wc;
    logic [5:0]  last_dt;
    logic [1:0]  last_vc;
    logic        last_long;

    always #2.5 clk = ~clk;

    pkt_frame_chk u0 (
        .clk(clk), .rst_n(rst_n), .mode_sync(mode_sync), .len_en(len_en),
        .len_bytes(len_bytes), .tmo_limit(tmo_limit), .irq_en(irq_en),
        .flag_clr(flag_clr), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .rx_sot(rx_sot), .rx_eot(rx_eot), .pkt_start(pkt_start),
        .pkt_done(pkt_done), .pkt_long(pkt_long), .pkt_vc(pkt_vc),
        .pkt_dtype(pkt_dtype), .pkt_wc(pkt_wc), .flags(flags), .irq(irq)
    );

    always @(posedge clk) begin
        #1;
        if (pkt_start) n_start++;
        if (pkt_done) begin
            n_done++;
            last_wc = pkt_wc; last_dt = pkt_dtype; last_vc = pkt_vc; last_long = pkt_long;
        end
    end

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", rq, act, exp);
        end
    endtask

    task automatic drv(input logic v, input logic [7:0] b, input logic s, input logic e);
        @(negedge clk);
        rx_valid = v; rx_byte = b; rx_sot = s; rx_eot = e; flag_clr = '0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drv(1'b0, 8'h00, 1'b0, 1'b0);
    endtask

    task automatic clear_all();
        @(negedge clk);
        rx_valid = 1'b0; rx_sot = 1'b0; rx_eot = 1'b0; flag_clr = '1;
        @(negedge clk);
        flag_clr = '0;
    endtask

    function automatic logic [5:0] col(input int k);
        int n = 0;
        logic [5:0] r = '0;
        for (int v = 7; v < 64; v++) begin
            int w = 0;
            for (int j = 0; j < 6; j++) w += (v >> j) & 1;
            if (w == 3 || w == 5) begin
                if (n == k) r = 6'(v);
                n++;
            end
        end
        return r;
    endfunction

    function automatic logic [15:0] crc_upd(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] r = c;
        for (int i = 0; i < 8; i++) r = ((r[0] ^ d[i]) != 0) ? ((r >> 1) ^ 16'h8408) : (r >> 1);
        return r;
    endfunction

    task automatic send_hdr(input logic [1:0] vc, input logic [5:0] dt, input logic [15:0] wc,
                            input logic [23:0] dflip, input logic [5:0] pflip,
                            input int npay, input logic crc_bad, input logic do_eot);
        logic [23:0] d;
        logic [5:0]  p;
        logic [15:0] c;
        logic [7:0]  b;
        d = {wc, vc, dt};
        p = '0;
        for (int k = 0; k < 24; k++) if (d[k]) p = p ^ col(k);
        d = d ^ dflip;
        p = p ^ pflip;
        drv(1'b0, 8'h00, 1'b1, 1'b0);
        drv(1'b1, d[7:0], 1'b0, 1'b0);
        drv(1'b1, d[15:8], 1'b0, 1'b0);
        drv(1'b1, d[23:16], 1'b0, 1'b0);
        drv(1'b1, {2'b00, p}, 1'b0, 1'b0);
        c = 16'hFFFF;
        for (int i = 0; i < npay; i++) begin
            b = 8'(i * 37 + 5);
            c = crc_upd(c, b);
            drv(1'b1, b, 1'b0, 1'b0);
        end
        if (dt >= 6'h10 && npay == int'(wc)) begin
            if (crc_bad) c = c ^ 16'h0100;
            drv(1'b1, c[7:0], 1'b0, 1'b0);
            drv(1'b1, c[15:8], 1'b0, 1'b0);
        end
        if (do_eot) drv(1'b0, 8'h00, 1'b0, 1'b1);
        idle(2);
    endtask

    task automatic sync_mark(input logic [7:0] code);
        drv(1'b1, 8'hFF, 1'b0, 1'b0);
        drv(1'b1, 8'h00, 1'b0, 1'b0);
        drv(1'b1, 8'h00, 1'b0, 1'b0);
        drv(1'b1, code, 1'b0, 1'b0);
    endtask

    task automatic sync_pay(input int n);
        for (int i = 0; i < n; i++) drv(1'b1, 8'(8'h21 + i), 1'b0, 1'b0);
    endtask

    task automatic t_reset();
        chk("R12 flags", flags, 0);
        chk("R12 irq", irq, 0);
        chk("R12 pulses", {pkt_start, pkt_done}, 0);
    endtask

    task automatic t_short();
        int s0 = n_start, d0 = n_done;
        send_hdr(2'd2, 6'h01, 16'h1234, '0, '0, 0, 1'b0, 1'b1);
        chk("R3 start", n_start - s0, 1);
        chk("R3 done", n_done - d0, 1);
        chk("R3 fields", {last_vc, last_dt, last_wc, last_long}, {2'd2, 6'h01, 16'h1234, 1'b0});
        chk("R10 evt only", flags, 8'h80);
        clear_all();
        chk("R11 cleared", flags, 0);
    endtask

    task automatic t_long();
        int d0 = n_done;
        send_hdr(2'd1, 6'h2A, 16'd6, '0, '0, 6, 1'b0, 1'b1);
        chk("R4 done", n_done - d0, 1);
        chk("R4 fields", {last_long, last_wc}, {1'b1, 16'd6});
        chk("R4 good crc", flags, 8'h80);
        clear_all();
        send_hdr(2'd0, 6'h2B, 16'd3, '0, '0, 3, 1'b1, 1'b1);
        chk("R4 bad crc", flags, 8'h84);
        irq_en = 8'h04; #0.1;
        chk("R11 irq on", irq, 1);
        irq_en = 8'h02; #0.1;
        chk("R11 irq masked", irq, 0);
        irq_en = 8'h00;
        clear_all();
        send_hdr(2'd0, 6'h30, 16'd0, '0, '0, 0, 1'b0, 1'b1);
        chk("R4 zero wc", flags, 8'h80);
        clear_all();
    endtask

    task automatic t_ecc();
        int s0 = n_start;
        send_hdr(2'd3, 6'h12, 16'h0005, 24'h002000, '0, 5, 1'b0, 1'b1);
        chk("R1 data fix flag", flags, 8'h81);
        chk("R1 corrected wc", last_wc, 16'h0005);
        clear_all();
        send_hdr(2'd0, 6'h05, 16'h00AA, '0, 6'h08, 0, 1'b0, 1'b1);
        chk("R1 parity fix", flags, 8'h81);
        clear_all();
        s0 = n_start;
        send_hdr(2'd1, 6'h22, 16'd4, 24'h020008, '0, 4, 1'b0, 1'b1);
        chk("R2 bad flag", flags, 8'h02);
        chk("R2 no start", n_start - s0, 0);
        clear_all();
    endtask

    task automatic t_order_hdr();
        int d0 = n_done;
        send_hdr(2'd0, 6'h2A, 16'd10, '0, '0, 3, 1'b0, 1'b1);
        chk("R5 early eot", flags, 8'h40);
        chk("R5 no done", n_done - d0, 0);
        clear_all();
        send_hdr(2'd0, 6'h2A, 16'd10, '0, '0, 2, 1'b0, 1'b0);
        drv(1'b0, 8'h00, 1'b1, 1'b0);
        drv(1'b0, 8'h00, 1'b0, 1'b1);
        idle(2);
        chk("R5 sot in packet", flags[3], 1);
        clear_all();
    endtask

    task automatic t_stall();
        tmo_limit = 16'd20;
        drv(1'b0, 8'h00, 1'b1, 1'b0);
        drv(1'b1, 8'h00, 1'b0, 1'b0);
        drv(1'b1, 8'h40, 1'b0, 1'b0);
        idle(10);
        chk("R9 not yet", flags[5], 0);
        idle(15);
        chk("R9 stall", flags, 8'h20);
        clear_all();
        send_hdr(2'd0, 6'h2C, 16'd2, '0, '0, 2, 1'b0, 1'b1);
        chk("R9 recovers", flags, 8'h80);
        tmo_limit = '0;
        clear_all();
    endtask

    task automatic t_sync();
        int d0;
        mode_sync = 1'b1;
        idle(2);
        d0 = n_done;
        sync_mark(8'h82); sync_pay(5); sync_mark(8'h81); idle(2);
        chk("R6 done", n_done - d0, 1);
        chk("R6 wc", last_wc, 5);
        chk("R6 flags", flags, 8'h80);
        clear_all();
        sync_mark(8'h83); idle(2);
        chk("R7 close idle", flags, 8'h08);
        clear_all();
        d0 = n_done;
        sync_mark(8'h80); sync_pay(2); sync_mark(8'h82); sync_pay(1); sync_mark(8'h83); idle(2);
        chk("R7 reopen", flags, 8'h88);
        chk("R7 wc after restart", last_wc, 1);
        clear_all();
    endtask

    task automatic t_noend();
        int d0 = n_done;
        len_en = 1'b1; len_bytes = 16'd3;
        sync_mark(8'h80); sync_pay(3);
        drv(1'b1, 8'h11, 1'b0, 1'b0); drv(1'b1, 8'h11, 1'b0, 1'b0); drv(1'b1, 8'h11, 1'b0, 1'b0);
        idle(1);
        chk("R8 before limit", flags[4], 0);
        drv(1'b1, 8'h11, 1'b0, 1'b0);
        idle(1);
        chk("R8 missing end", flags, 8'h10);
        chk("R8 no done", n_done - d0, 0);
        sync_mark(8'h82); sync_pay(3); sync_mark(8'h83); idle(2);
        chk("R8 next packet", flags, 8'h90);
        chk("R8 next done", n_done - d0, 1);
        len_en = 1'b0;
        clear_all();
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog act=running exp=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        idle(2);
        t_short();
        t_long();
        t_ecc();
        t_order_hdr();
        t_stall();
        t_sync();
        t_noend();
        idle(3);
        finish_run();
    end

endmodule